// File: doc/BRIEF.md
# Receive Watermark and Copy-Length Controller

This block sits beside the receive packet buffer and the receive DMA engine of a network interface. It watches the byte occupancy of the receive buffer and compares it against two programmable thresholds. From these it keeps a hysteretic "buffer is low" flag: the flag turns on when occupancy drops under the low threshold, turns off when occupancy climbs over the high threshold, and keeps its value in the band between them. The same comparisons drive a receive-high status bit and a receive-high interrupt request, which is raised when a packet arrives at a buffer that is already at or above the high threshold. On the transmit side it raises a packet-sent request for every transmitted packet, adds a transmit-low request when the transmit buffer has drained under its low threshold, and reports a transmit-full status when free transmit space cannot hold one maximum-sized copy.

For every receive copy the DMA engine strobes the block with a 64-bit descriptor and the number of bytes still left in the current packet. The block returns the number of bytes to copy one cycle later. That number is normally the smaller of the descriptor length and the bytes left. Under a zero-copy or delayed-copy policy, while the receive buffer is low and the descriptor does not forbid it, a long copy is cut down to a short header-sized copy. The block also checks that the copy settings are consistent and flags a bad setting.

Top module: `rx_wmark_ctrl`

## Requirements
- R1: `rx_low` is 1 out of reset. One cycle after `rx_occ` is strictly below `thr_rx_low` and not above `thr_rx_high`, `rx_low` is 1.
- R2: One cycle after `rx_occ` is strictly above `thr_rx_high`, `rx_low` is 0. This also holds when `rx_occ` is at the same time below `thr_rx_low`, so clearing takes priority.
- R3: While `thr_rx_low <= rx_occ <= thr_rx_high`, `rx_low` keeps its previous value. Both bounds are inclusive.
- R4: `irq_rx_high` is a one-cycle pulse in the cycle after a cycle with `rx_arrive` = 1 and `rx_occ >= thr_rx_high`. In every other cycle it is 0.
- R5: One cycle after `copy_go`, `copy_valid` is 1 for one cycle and `copy_len` holds the base length. The base length is the smaller of the descriptor length field (bits 59:40, zero-extended) and `pkt_left`. Without `copy_go`, `copy_valid` is 0 and `copy_len`/`copy_cut` keep their last values.
- R6: A copy is cut when four conditions hold: `cfg_zero_copy` or `cfg_delay_copy` is 1, descriptor bit 61 (no-delay) is 0, `rx_low` is 1 in the cycle of `copy_go`, and the base length is strictly greater than `zc_mark`. A cut copy reports `copy_len` = `zc_size` and `copy_cut` = 1. Otherwise `copy_cut` is 0 and the base length is used.
- R7: One cycle after `tx_sent`, `irq_tx_pkt` pulses. `irq_tx_low` pulses in that same cycle only if `tx_occ < thr_tx_low` at the time of `tx_sent`.
- R8: Both status outputs are registered, one cycle behind their inputs. `rx_high_stat` is `rx_occ > thr_rx_high`. `tx_full_stat` is `tx_free < max_tx_copy`.
- R9: `cfg_bad` is 1 one cycle after `max_rx_copy < zc_mark` or `zc_size >= zc_mark`; otherwise it is 0.
- R10: Descriptor bits 39:0 (address), bit 60 (virtual-address flag) and bits 63:62 do not affect `copy_len` or `copy_cut`.
- R11: During reset every output is 0 except `rx_low`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_occ | input | CNT_W | Receive buffer occupancy in bytes |
| rx_arrive | input | 1 | A packet is arriving at the receive buffer |
| tx_occ | input | CNT_W | Transmit buffer occupancy in bytes |
| tx_free | input | CNT_W | Transmit buffer free space in bytes |
| tx_sent | input | 1 | A packet has been transmitted |
| cfg_zero_copy | input | 1 | Zero-copy receive policy enable |
| cfg_delay_copy | input | 1 | Delayed-copy policy enable |
| thr_rx_low | input | CNT_W | Receive low threshold |
| thr_rx_high | input | CNT_W | Receive high threshold |
| thr_tx_low | input | CNT_W | Transmit low threshold |
| max_rx_copy | input | CNT_W | Largest receive copy in bytes |
| max_tx_copy | input | CNT_W | Largest transmit copy in bytes |
| zc_size | input | CNT_W | Length used for a cut copy |
| zc_mark | input | CNT_W | Base length above which a copy may be cut |
| copy_go | input | 1 | Compute a copy length this cycle |
| desc | input | 64 | Receive descriptor |
| pkt_left | input | CNT_W | Bytes left in the current packet |
| copy_len | output | CNT_W | Computed copy length |
| copy_valid | output | 1 | `copy_len` is new this cycle |
| copy_cut | output | 1 | The copy was cut to `zc_size` |
| rx_low | output | 1 | Hysteretic receive-low flag |
| rx_high_stat | output | 1 | Receive occupancy above high threshold |
| tx_full_stat | output | 1 | Transmit free space below one maximum copy |
| cfg_bad | output | 1 | Copy settings are inconsistent |
| irq_rx_high | output | 1 | Receive-high interrupt request pulse |
| irq_tx_pkt | output | 1 | Packet-sent interrupt request pulse |
| irq_tx_low | output | 1 | Transmit-low interrupt request pulse |

## Verification
The hysteresis is driven by a walk of occupancy values that goes from inside the band to over the high threshold, back into the band, under the low threshold, and onto each threshold exactly. This walk tells a correct hold apart from an off-by-one comparison and from a plain two-level compare. The copy length is tried with the descriptor length as the smaller value and then with the bytes left as the smaller value, and with each cut condition removed one at a time: no policy, no-delay set, flag clear, and base exactly equal to the mark. Each removed condition must leave the base length in place. A further pass changes only the address and flag bits of the descriptor, and the transmit and configuration checks each put their inputs on both sides of the comparison.

// File: rtl/rwc_pkg.sv
// Shared descriptor layout for the receive watermark controller.
// Assumes a 64-bit descriptor: address 39:0, length 59:40,
// virtual-address flag 60, no-delay flag 61, bits 63:62 unused.
package rwc_pkg;

    localparam int DESC_W   = 64;
    localparam int D_ADDR_W = 40;
    localparam int D_LEN_W  = 20;

    typedef struct packed {
        logic [1:0]          spare;
        logic                no_delay;
        logic                virt;
        logic [D_LEN_W-1:0]  len;
        logic [D_ADDR_W-1:0] addr;
    } rwc_desc_t;

endpackage

// File: rtl/rwc_hyst.sv
// Hysteretic low flag for a byte-occupancy count.
// Sets when occupancy is below the low threshold, clears when above the
// high threshold (clear wins if both hold), holds otherwise.
// Assumes thresholds are static while meaningful; resets to 1 (empty).
module rwc_hyst #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] thr_hi,
    output logic             low_o
);

    logic below_lo;
    logic above_hi;

    // Threshold comparisons against the current occupancy.
    always_comb begin
        below_lo = (occ < thr_lo);
        above_hi = (occ > thr_hi);
    end

    // Flag register with clear priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_o <= 1'b1;
        end else if (above_hi) begin
            low_o <= 1'b0;
        end else if (below_lo) begin
            low_o <= 1'b1;
        end
    end

endmodule

// File: rtl/rwc_copy_len.sv
// Receive copy-length computation.
// On a strobe, registers min(descriptor length, bytes left), cut down to
// the zero-copy size when the policy is on, the descriptor allows it, the
// buffer is low and the base length exceeds the mark. Result and a valid
// pulse appear one cycle after the strobe; the length holds otherwise.
module rwc_copy_len #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] d_len,
    input  logic             d_no_delay,
    input  logic [CNT_W-1:0] pkt_left,
    input  logic             policy_en,
    input  logic             low_in,
    input  logic [CNT_W-1:0] zc_mark,
    input  logic [CNT_W-1:0] zc_size,
    output logic [CNT_W-1:0] len_o,
    output logic             valid_o,
    output logic             cut_o
);

    localparam int PAD_W = CNT_W - LEN_W;

    logic [CNT_W-1:0] len_ext;
    logic [CNT_W-1:0] base_len;
    logic             do_cut;
    logic [CNT_W-1:0] final_len;

    // Widen the descriptor length to the count width.
    always_comb len_ext = {{PAD_W{1'b0}}, d_len};

    // Base length is the smaller of descriptor length and bytes left.
    always_comb base_len = (len_ext < pkt_left) ? len_ext : pkt_left;

    // Decide whether the copy is cut to the header-sized length.
    always_comb begin
        do_cut    = policy_en && !d_no_delay && low_in && (base_len > zc_mark);
        final_len = do_cut ? zc_size : base_len;
    end

    // Register the result on a strobe; valid is a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o   <= '0;
            cut_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= go;
            if (go) begin
                len_o <= final_len;
                cut_o <= do_cut;
            end
        end
    end

endmodule

// File: rtl/rwc_reg_vec.sv
// Plain registered vector with a parameterised reset value, used for
// the status bits and the single-cycle interrupt request pulses.
// Assumes requests are level for exactly the cycles they apply.
module rwc_reg_vec #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    // One flop per bit, synchronous reset.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= RST_VAL[i];
            else        q[i] <= d[i];
        end
    end

endmodule

// File: rtl/rx_wmark_ctrl.sv
// Receive watermark and copy-length controller (top).
// Tracks receive occupancy with a hysteretic low flag, reports receive
// high and transmit full status, requests interrupts on receive-high
// arrival and on each transmitted packet (plus transmit-low), computes
// the receive copy length and flags inconsistent copy settings.
// Assumes CNT_W is at least the descriptor length width.
module rx_wmark_ctrl
    import rwc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_occ,
    input  logic              rx_arrive,
    input  logic [CNT_W-1:0]  tx_occ,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic              tx_sent,
    input  logic              cfg_zero_copy,
    input  logic              cfg_delay_copy,
    input  logic [CNT_W-1:0]  thr_rx_low,
    input  logic [CNT_W-1:0]  thr_rx_high,
    input  logic [CNT_W-1:0]  thr_tx_low,
    input  logic [CNT_W-1:0]  max_rx_copy,
    input  logic [CNT_W-1:0]  max_tx_copy,
    input  logic [CNT_W-1:0]  zc_size,
    input  logic [CNT_W-1:0]  zc_mark,
    input  logic              copy_go,
    input  logic [DESC_W-1:0] desc,
    input  logic [CNT_W-1:0]  pkt_left,
    output logic [CNT_W-1:0]  copy_len,
    output logic              copy_valid,
    output logic              copy_cut,
    output logic              rx_low,
    output logic              rx_high_stat,
    output logic              tx_full_stat,
    output logic              cfg_bad,
    output logic              irq_rx_high,
    output logic              irq_tx_pkt,
    output logic              irq_tx_low
);

    localparam int N_IRQ  = 3;
    localparam int N_STAT = 3;

    rwc_desc_t         dsc;
    logic              policy_en;
    logic [N_IRQ-1:0]  irq_req;
    logic [N_IRQ-1:0]  irq_q;
    logic [N_STAT-1:0] stat_d;
    logic [N_STAT-1:0] stat_q;

    // Decode the descriptor fields and the copy policy.
    always_comb begin
        dsc       = rwc_desc_t'(desc);
        policy_en = cfg_zero_copy || cfg_delay_copy;
    end

    rwc_hyst #(.CNT_W(CNT_W)) u_hyst (
        .clk    (clk),
        .rst_n  (rst_n),
        .occ    (rx_occ),
        .thr_lo (thr_rx_low),
        .thr_hi (thr_rx_high),
        .low_o  (rx_low)
    );

    rwc_copy_len #(.CNT_W(CNT_W), .LEN_W(D_LEN_W)) u_copy (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (copy_go),
        .d_len      (dsc.len),
        .d_no_delay (dsc.no_delay),
        .pkt_left   (pkt_left),
        .policy_en  (policy_en),
        .low_in     (rx_low),
        .zc_mark    (zc_mark),
        .zc_size    (zc_size),
        .len_o      (copy_len),
        .valid_o    (copy_valid),
        .cut_o      (copy_cut)
    );

    // Interrupt requests: receive-high on arrival, transmit packet/low.
    always_comb begin
        irq_req[0] = rx_arrive && (rx_occ >= thr_rx_high);
        irq_req[1] = tx_sent;
        irq_req[2] = tx_sent && (tx_occ < thr_tx_low);
    end

    rwc_reg_vec #(.N(N_IRQ), .RST_VAL('0)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_req),
        .q     (irq_q)
    );

    // Status comparisons and configuration consistency.
    always_comb begin
        stat_d[0] = (rx_occ > thr_rx_high);
        stat_d[1] = (tx_free < max_tx_copy);
        stat_d[2] = (max_rx_copy < zc_mark) || (zc_size >= zc_mark);
    end

    rwc_reg_vec #(.N(N_STAT), .RST_VAL('0)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_d),
        .q     (stat_q)
    );

    // Map the registered vectors onto named outputs.
    always_comb begin
        irq_rx_high  = irq_q[0];
        irq_tx_pkt   = irq_q[1];
        irq_tx_low   = irq_q[2];
        rx_high_stat = stat_q[0];
        tx_full_stat = stat_q[1];
        cfg_bad      = stat_q[2];
    end

endmodule

// File: rtl/rwc_checker.sv
// Assertion checker for rx_wmark_ctrl, attached by bind below.
module rwc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_occ,
    input logic             rx_arrive,
    input logic             tx_sent,
    input logic [CNT_W-1:0] thr_rx_low,
    input logic [CNT_W-1:0] thr_rx_high,
    input logic [CNT_W-1:0] zc_size,
    input logic             copy_go,
    input logic [63:0]      desc,
    input logic [CNT_W-1:0] pkt_left,
    input logic [CNT_W-1:0] copy_len,
    input logic             copy_valid,
    input logic             copy_cut,
    input logic             rx_low,
    input logic             irq_rx_high,
    input logic             irq_tx_pkt,
    input logic             irq_tx_low
);

    AST_LOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_occ < thr_rx_low) && !(rx_occ > thr_rx_high) |=> rx_low); // R1

    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_occ > thr_rx_high) |=> !rx_low); // R2

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_occ < thr_rx_low) && !(rx_occ > thr_rx_high) |=> $stable(rx_low)); // R3

    AST_RXHI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_arrive |=> !irq_rx_high); // R4

    AST_COPY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_go |=> copy_valid); // R5

    AST_COPY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_go |=> !copy_valid && $stable(copy_len)); // R5

    AST_COPY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        copy_go && !copy_cut |=> copy_cut || (copy_len <= $past(pkt_left))); // R5

    AST_CUT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_go |=> !copy_cut || (copy_len == $past(zc_size))); // R6

    AST_TXLOW_WITH_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_low |-> irq_tx_pkt); // R7

    AST_TXPKT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sent |=> irq_tx_pkt); // R7

    AST_DESC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        copy_go |-> !$isunknown(desc)); // R10

endmodule

bind rx_wmark_ctrl rwc_checker #(.CNT_W(CNT_W)) u_rwc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_occ      (rx_occ),
    .rx_arrive   (rx_arrive),
    .tx_sent     (tx_sent),
    .thr_rx_low  (thr_rx_low),
    .thr_rx_high (thr_rx_high),
    .zc_size     (zc_size),
    .copy_go     (copy_go),
    .desc        (desc),
    .pkt_left    (pkt_left),
    .copy_len    (copy_len),
    .copy_valid  (copy_valid),
    .copy_cut    (copy_cut),
    .rx_low      (rx_low),
    .irq_rx_high (irq_rx_high),
    .irq_tx_pkt  (irq_tx_pkt),
    .irq_tx_low  (irq_tx_low)
);

// File: tb/test_rx_wmark_ctrl.sv
`timescale 1ns/1ps
module test_rx_wmark_ctrl;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  rx_occ, tx_occ, tx_free;
    logic          rx_arrive, tx_sent, copy_go;
    logic          cfg_zero_copy, cfg_delay_copy;
    logic [W-1:0]  thr_rx_low, thr_rx_high, thr_tx_low;
    logic [W-1:0]  max_rx_copy, max_tx_copy, zc_size, zc_mark, pkt_left;
    logic [63:0]   desc;
    logic [W-1:0]  copy_len;
    logic          copy_valid, copy_cut, rx_low, rx_high_stat, tx_full_stat;
    logic          cfg_bad, irq_rx_high, irq_tx_pkt, irq_tx_low;

    always #4 clk = ~clk;

    rx_wmark_ctrl #(.CNT_W(W)) i_rx_wmark_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_occ(rx_occ), .rx_arrive(rx_arrive),
        .tx_occ(tx_occ), .tx_free(tx_free), .tx_sent(tx_sent),
        .cfg_zero_copy(cfg_zero_copy), .cfg_delay_copy(cfg_delay_copy),
        .thr_rx_low(thr_rx_low), .thr_rx_high(thr_rx_high),
        .thr_tx_low(thr_tx_low), .max_rx_copy(max_rx_copy),
        .max_tx_copy(max_tx_copy), .zc_size(zc_size), .zc_mark(zc_mark),
        .copy_go(copy_go), .desc(desc), .pkt_left(pkt_left),
        .copy_len(copy_len), .copy_valid(copy_valid), .copy_cut(copy_cut),
        .rx_low(rx_low), .rx_high_stat(rx_high_stat),
        .tx_full_stat(tx_full_stat), .cfg_bad(cfg_bad),
        .irq_rx_high(irq_rx_high), .irq_tx_pkt(irq_tx_pkt),
        .irq_tx_low(irq_tx_low)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] len;
        logic [9:0]   bits; // valid,cut,low,rh_st,tf_st,bad,irq_rh,irq_tp,irq_tl,spare
    } exp_t;

    exp_t          sb_q[$];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;
    logic          m_low;
    logic [W-1:0]  m_len;
    logic          m_cut;

    function automatic logic [63:0] mk_desc(input logic nd, input logic vt,
                                            input logic [19:0] ln,
                                            input logic [39:0] ad);
        return {2'b00, nd, vt, ln, ad};
    endfunction

    function automatic logic [9:0] act_bits();
        return {copy_valid, copy_cut, rx_low, rx_high_stat, tx_full_stat,
                cfg_bad, irq_rx_high, irq_tx_pkt, irq_tx_low, 1'b0};
    endfunction

    // Driver: compute the expected outputs for the inputs set this cycle,
    // queue them, then move to the next falling edge and drop strobes.
    task automatic step(input string tag);
        exp_t         e;
        logic [W-1:0] base, ln;
        logic         cut, lo_next;
        ln   = {12'd0, desc[59:40]};
        base = (ln < pkt_left) ? ln : pkt_left;
        cut  = (cfg_zero_copy || cfg_delay_copy) && !desc[61] && m_low
               && (base > zc_mark);
        if (copy_go) begin
            m_len = cut ? zc_size : base;
            m_cut = cut;
        end
        lo_next = (rx_occ > thr_rx_high) ? 1'b0 :
                  (rx_occ < thr_rx_low)  ? 1'b1 : m_low;
        m_low = lo_next;
        e.tag  = tag;
        e.len  = m_len;
        e.bits = {copy_go, m_cut, m_low, rx_occ > thr_rx_high,
                  tx_free < max_tx_copy,
                  (max_rx_copy < zc_mark) || (zc_size >= zc_mark),
                  rx_arrive && (rx_occ >= thr_rx_high), tx_sent,
                  tx_sent && (tx_occ < thr_tx_low), 1'b0};
        sb_q.push_back(e);
        @(negedge clk);
        copy_go   = 1'b0;
        rx_arrive = 1'b0;
        tx_sent   = 1'b0;
    endtask

    // Monitor: just after each rising edge, compare against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (act_bits() !== e.bits || copy_len !== e.len) begin
                    n_bad++;
                    $display("FAIL %s: got len=%0d bits=%b, expected len=%0d bits=%b",
                             e.tag, copy_len, act_bits(), e.len, e.bits);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rx_occ = 500; tx_occ = 1000; tx_free = 5000;
        rx_arrive = 0; tx_sent = 0; copy_go = 0;
        cfg_zero_copy = 0; cfg_delay_copy = 0;
        thr_rx_low = 100; thr_rx_high = 1000; thr_tx_low = 200;
        max_rx_copy = 1024; max_tx_copy = 1500; zc_size = 64; zc_mark = 256;
        pkt_left = 2000; desc = mk_desc(0, 0, 20'd300, 40'h12_3456_789A);
        m_low = 1'b1; m_len = '0; m_cut = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (act_bits() !== 10'b0010000000 || copy_len !== '0) begin
            n_bad++;
            $display("FAIL R11 reset: got len=%0d bits=%b, expected len=0 bits=%b",
                     copy_len, act_bits(), 10'b0010000000);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Hysteresis walk
        rx_occ = 500;  step("R3 hold high in band");
        rx_occ = 1001; step("R2 clear above high");
        rx_occ = 1000; step("R3 hold at high bound");
        rx_occ = 100;  step("R3 hold at low bound");
        rx_occ = 99;   step("R1 set below low");
        rx_occ = 500;  step("R3 hold set in band");
        thr_rx_low = 2000; rx_occ = 1500; step("R2 clear wins over set");
        thr_rx_low = 100;  rx_occ = 50;   step("R1 set again");

        // Receive-high interrupt
        rx_occ = 1000; rx_arrive = 1; step("R4 arrive at high");
        rx_occ = 999;  rx_arrive = 1; step("R4 arrive below high");
        rx_occ = 1200; step("R4 no arrival above high");
        rx_occ = 50;   step("R1 restore low");

        // Copy length base
        desc = mk_desc(0, 0, 20'd300, 40'h1); pkt_left = 2000; copy_go = 1;
        step("R5 desc length smaller");
        step("R5 hold without strobe");
        desc = mk_desc(0, 0, 20'd5000, 40'h2); pkt_left = 700; copy_go = 1;
        step("R5 bytes left smaller");

        // Zero-copy cut
        cfg_zero_copy = 1;
        desc = mk_desc(0, 0, 20'd300, 40'h3); pkt_left = 2000; copy_go = 1;
        step("R6 cut under zero copy");
        desc = mk_desc(0, 0, 20'd256, 40'h3); copy_go = 1;
        step("R6 base equal mark no cut");
        desc = mk_desc(1, 0, 20'd300, 40'h3); copy_go = 1;
        step("R6 no-delay blocks cut");
        cfg_zero_copy = 0; cfg_delay_copy = 1;
        desc = mk_desc(0, 0, 20'd900, 40'h4); copy_go = 1;
        step("R6 cut under delayed copy");
        cfg_delay_copy = 0; copy_go = 1;
        step("R6 no policy no cut");
        cfg_delay_copy = 1; rx_occ = 1500; step("R2 clear before copy");
        rx_occ = 500; copy_go = 1; step("R6 flag clear no cut");
        rx_occ = 50; step("R1 set for address test");
        desc = mk_desc(0, 0, 20'd900, 40'hFF_FFFF_FFFF); copy_go = 1;
        step("R10 address bits ignored");
        desc = mk_desc(0, 1, 20'd900, 40'h0) | 64'hC000_0000_0000_0000; copy_go = 1;
        step("R10 virtual and spare bits ignored");
        cfg_delay_copy = 0;

        // Transmit interrupts and status
        tx_sent = 1; tx_occ = 150; step("R7 sent below tx low");
        tx_sent = 1; tx_occ = 200; step("R7 sent at tx low");
        tx_free = 1499; step("R8 tx full");
        tx_free = 1500; step("R8 tx not full at bound");

        // Configuration check
        max_rx_copy = 255; step("R9 max copy below mark");
        max_rx_copy = 1024; zc_size = 256; step("R9 size equal mark");
        zc_size = 255; step("R9 consistent");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule